// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block performs one integer operation on every element of two wide operands at the same time. Each operand is read as a row of independent elements of 8, 16, 32 or 64 bits, so a 128-bit word holds 16, 8, 4 or 2 lanes. The block provides lane-wise add, subtract, equality compare, signed greater-than compare, logical left and right shifts by an immediate count, and the bitwise AND, OR and XOR functions.

Add and subtract use one byte-sliced carry chain. The element-size select cuts that chain at every lane boundary, so no carry or borrow passes from one lane into the next. A shift with 8-bit elements is not supported. Such a request, and any undefined opcode, raises an illegal flag and returns a zero result. All outputs are registered. The block has a latency of one cycle and can take a new operation on every cycle.

Top module: `simd_lane_alu`

## Requirements
- R1: When `in_vld` is high on a clock edge, `out_vld` is high after that edge and `out_res` and `out_illegal` show the result of that operation. When `in_vld` is low, `out_vld` is low after the edge.
- R2: Opcode 0 (add) puts `(a + b) mod 2^W` in every lane, where W is the element width. `in_esz` selects W: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. Lanes occupy consecutive W-bit slices starting at bit 0. No carry crosses a lane boundary.
- R3: Opcode 1 (subtract) puts `(a - b) mod 2^W` in every lane. No borrow crosses a lane boundary.
- R4: Opcode 2 (equal) sets a lane to all ones when the two elements are equal and to all zeros when they differ.
- R5: Opcode 3 (greater) sets a lane to all ones when element a is greater than element b as signed two's-complement values, and to all zeros otherwise.
- R6: Opcode 4 shifts each lane left by `in_shamt` and opcode 5 shifts each lane right by `in_shamt`. Both shifts are logical and fill the vacated bits with zeros.
- R7: For a shift, a lane returns zero when `in_shamt` is greater than or equal to W.
- R8: A shift requested with 8-bit elements (`in_esz` = 0) sets `out_illegal` and returns a zero result.
- R9: Opcodes 6, 7 and 8 (AND, OR, XOR) give the full-width bitwise result, and the element size has no effect on it.
- R10: Opcodes 9 to 15 are undefined. They set `out_illegal` and return a zero result.
- R11: After a synchronous reset, `out_vld`, `out_illegal` and `out_res` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Opcode, encoded as listed in the requirements |
| in_esz | input | 2 | Element size: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, 3 for 64-bit |
| in_shamt | input | 7 | Shift count that applies to every lane |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | 128 | Registered lane-wise result |
| out_illegal | output | 1 | The operation was an unsupported shift or an undefined opcode |

## Verification
The checker looks at every cycle. It confirms that valid follows the input strobe with one cycle of delay and that an illegal flag always comes with a zero result. It confirms that a byte-shift request is flagged, that a 64-bit compare lane is either all ones or all zeros, and that the second byte of an 8-bit add is unaffected by the carry out of the first byte. It also confirms that AND is independent of the element size. Only the bench's sweeps can show that every lane of every operation and size matches an arithmetic model, including the carry-boundary patterns, signed edge values, and shift counts at and above the element width.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CEQ = 4'd2,
    OP_CGT = 4'd3,
    OP_SHL = 4'd4,
    OP_SHR = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8
  } lane_op_e;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } lane_esz_e;

  localparam int NUM_ESZ = 4;
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        esz,
  output logic [DATA_W-1:0] sum
);
  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] b_eff;
  assign b_eff = sub ? ~b : b;

  // byte-sliced ripple; the lane head takes the injected carry instead
  always_comb begin
    logic       carry;
    logic [8:0] part;
    int         bpl;
    bpl   = 1 << esz;
    carry = 1'b0;
    sum   = '0;
    for (int i = 0; i < NBYTE; i++) begin
      if ((i & (bpl - 1)) == 0) carry = sub;
      part = {1'b0, a[i*8 +: 8]} + {1'b0, b_eff[i*8 +: 8]} + {8'd0, carry};
      sum[i*8 +: 8] = part[7:0];
      carry = part[8];
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        esz,
  output logic [DATA_W-1:0] eq_mask,
  output logic [DATA_W-1:0] gt_mask
);
  import simd_pkg::*;

  logic [DATA_W-1:0] eqv [NUM_ESZ];
  logic [DATA_W-1:0] gtv [NUM_ESZ];

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_size
    localparam int W     = 8 << g;
    localparam int LANES = DATA_W / W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [W-1:0] ea, eb;
      assign ea = a[l*W +: W];
      assign eb = b[l*W +: W];
      assign eqv[g][l*W +: W] = {W{ea == eb}};
      assign gtv[g][l*W +: W] = {W{$signed(ea) > $signed(eb)}};
    end
  end

  assign eq_mask = eqv[esz];
  assign gt_mask = gtv[esz];
endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
  parameter int DATA_W = 128,
  parameter int SH_W   = 7
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   shamt,
  input  logic              right,
  input  logic [1:0]        esz,
  output logic [DATA_W-1:0] res
);
  import simd_pkg::*;

  logic [DATA_W-1:0] shv [NUM_ESZ];

  // byte elements are not supported by the shift unit
  assign shv[0] = '0;

  for (genvar g = 1; g < NUM_ESZ; g++) begin : g_size
    localparam int W     = 8 << g;
    localparam int LANES = DATA_W / W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [W-1:0] ea;
      logic         too_far;
      assign ea      = a[l*W +: W];
      assign too_far = (int'(shamt) >= W);
      assign shv[g][l*W +: W] = too_far ? '0 :
                                right   ? (ea >> shamt) : (ea << shamt);
    end
  end

  assign res = shv[esz];
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DATA_W = 128,
  parameter int SH_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [3:0]        in_op,
  input  logic [1:0]        in_esz,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res,
  output logic              out_illegal
);
  import simd_pkg::*;

  lane_op_e          op;
  logic [DATA_W-1:0] add_res, eq_res, gt_res, sh_res;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ill;
  logic              is_sub;

  assign op     = lane_op_e'(in_op);
  assign is_sub = (op == OP_SUB);

  simd_seg_adder #(.DATA_W(DATA_W)) u_add (
    .a   (in_a),
    .b   (in_b),
    .sub (is_sub),
    .esz (in_esz),
    .sum (add_res)
  );

  simd_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a       (in_a),
    .b       (in_b),
    .esz     (in_esz),
    .eq_mask (eq_res),
    .gt_mask (gt_res)
  );

  simd_lane_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
    .a     (in_a),
    .shamt (in_shamt),
    .right (op == OP_SHR),
    .esz   (in_esz),
    .res   (sh_res)
  );

  always_comb begin
    nxt_ill = 1'b0;
    nxt_res = '0;
    case (op)
      OP_ADD, OP_SUB: nxt_res = add_res;
      OP_CEQ:         nxt_res = eq_res;
      OP_CGT:         nxt_res = gt_res;
      OP_SHL, OP_SHR: begin
        if (in_esz == ESZ_8) nxt_ill = 1'b1;
        else                 nxt_res = sh_res;
      end
      OP_AND:         nxt_res = in_a & in_b;
      OP_OR:          nxt_res = in_a | in_b;
      OP_XOR:         nxt_res = in_a ^ in_b;
      default:        nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_res     <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res     <= nxt_res;
        out_illegal <= nxt_ill;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W = 128,
  parameter int SH_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [3:0]        in_op,
  input logic [1:0]        in_esz,
  input logic [SH_W-1:0]   in_shamt,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res,
  input logic              out_illegal
);
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_byte_lane_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_op == 4'd0 && in_esz == 2'd0) |=>
      (out_res[15:8] == $past(in_a[15:8] + in_b[15:8])));
  p_cmp_all_or_none_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_op == 4'd2 && in_esz == 2'd3) |=>
      (out_res[63:0] == '0 || out_res[63:0] == '1));
  p_byte_shift_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (in_op == 4'd4 || in_op == 4'd5) && in_esz == 2'd0) |=>
      (out_illegal && out_res == '0));
  p_and_size_free_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_op == 4'd6) |=> (out_res == $past(in_a & in_b)));
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_res == '0));
  p_shamt_unused_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_op == 4'd4 && in_esz == 2'd3 && in_shamt >= 7'd64) |=>
      (out_res == '0));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_vld      (in_vld),
  .in_op       (in_op),
  .in_esz      (in_esz),
  .in_shamt    (in_shamt),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_vld     (out_vld),
  .out_res     (out_res),
  .out_illegal (out_illegal)
);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [3:0]   in_op = '0;
  logic [1:0]   in_esz = '0;
  logic [6:0]   in_shamt = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_vld;
  logic [127:0] out_res;
  logic         out_illegal;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  simd_lane_alu u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_esz(in_esz),
    .in_shamt(in_shamt), .in_a(in_a), .in_b(in_b),
    .out_vld(out_vld), .out_res(out_res), .out_illegal(out_illegal)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic longint sx(longint unsigned v, int w);
    longint unsigned s;
    if (w == 64) return longint'(v);
    s = 64'd1 << (w - 1);
    return longint'(v ^ s) - longint'(s);
  endfunction

  function automatic string tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6/R7/R8";
      6, 7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [128:0] model(logic [127:0] a, logic [127:0] b,
                                         int es, int op, int sh);
    logic [127:0]    r;
    longint unsigned msk, ea, eb, v;
    int              w;
    w   = 8 << es;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
    r   = '0;
    if (op >= 9 || ((op == 4 || op == 5) && es == 0)) return {1'b1, 128'd0};
    if (op == 6) return {1'b0, a & b};
    if (op == 7) return {1'b0, a | b};
    if (op == 8) return {1'b0, a ^ b};
    for (int l = 0; l < 128 / w; l++) begin
      ea = 64'(a >> (l * w)) & msk;
      eb = 64'(b >> (l * w)) & msk;
      case (op)
        0: v = ea + eb;
        1: v = ea - eb;
        2: v = (ea == eb) ? '1 : '0;
        3: v = (sx(ea, w) > sx(eb, w)) ? '1 : '0;
        4: v = (sh >= w) ? 0 : (ea << sh);
        default: v = (sh >= w) ? 0 : (ea >> sh);
      endcase
      r = r | (128'(v & msk) << (l * w));
    end
    return {1'b0, r};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // drive at negedge, result registered at next posedge, sampled next negedge
  task automatic run(logic [127:0] a, logic [127:0] b, int es, int op, int sh);
    logic [128:0] exp;
    exp = model(a, b, es, op, sh);
    @(negedge clk);
    in_vld = 1'b1; in_a = a; in_b = b;
    in_esz = 2'(es); in_op = 4'(op); in_shamt = 7'(sh);
    @(negedge clk);
    in_vld = 1'b0;
    tests++;
    if (out_vld !== 1'b1 || out_illegal !== exp[128] || out_res !== exp[127:0]) begin
      fails++;
      $display("FAIL %s (R1) op=%0d es=%0d sh=%0d: got vld=%b ill=%b res=%h expected vld=1 ill=%b res=%h",
               tag(op), op, es, sh, out_vld, out_illegal, out_res, exp[128], exp[127:0]);
    end
  endtask

  initial begin
    logic [127:0] r;
    repeat (3) @(negedge clk);
    tests++;  // R11 reset state
    if (out_vld !== 1'b0 || out_illegal !== 1'b0 || out_res !== '0) begin
      fails++;
      $display("FAIL R11 reset: got vld=%b ill=%b res=%h expected 0 0 0",
               out_vld, out_illegal, out_res);
    end
    rst = 1'b0;
    @(negedge clk);
    tests++;  // R1 idle
    if (out_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle valid: got %b expected 0", out_vld);
    end

    for (int es = 0; es < 4; es++) begin
      for (int op = 0; op < 16; op++) begin
        run('0, '0, es, op, 0);
        run('1, {16{8'h01}}, es, op, 1);          // carry ripple boundaries
        run({16{8'h80}}, {16{8'h7f}}, es, op, 3);  // signed edges
        run({8{16'h0000}}, {16{8'h01}}, es, op, 7); // borrow boundaries
        r = rnd128();
        run(r, r, es, op, 2);
        for (int k = 0; k < 20; k++) run(rnd128(), rnd128(), es, op, int'($urandom % 80));
      end
    end

    // shift count sweep across and beyond every element width (R7)
    for (int es = 0; es < 4; es++)
      for (int sh = 0; sh < 128; sh++) begin
        run(rnd128(), '0, es, 4, sh);
        run(rnd128(), '0, es, 5, sh);
      end

    // back-to-back issue: valid follows strobe every cycle (R1)
    @(negedge clk);
    in_vld = 1'b1; in_op = 4'd6; in_esz = 2'd1; in_a = '1; in_b = {8{16'h00ff}};
    @(negedge clk);
    in_a = {8{16'hff00}};
    tests++;
    if (out_vld !== 1'b1 || out_res !== {8{16'h00ff}}) begin
      fails++;
      $display("FAIL R1 stream first: got vld=%b res=%h expected 1 %h", out_vld, out_res, {8{16'h00ff}});
    end
    @(negedge clk);
    in_vld = 1'b0;
    tests++;
    if (out_vld !== 1'b1 || out_res !== '0) begin
      fails++;
      $display("FAIL R1 stream second: got vld=%b res=%h expected 1 0", out_vld, out_res);
    end
    @(negedge clk);
    tests++;
    if (out_vld !== 1'b0 || out_res !== '0) begin
      fails++;
      $display("FAIL R1 hold: got vld=%b res=%h expected 0 held 0", out_vld, out_res);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule